// File: doc/BRIEF.md
# Banked UART configuration register decoder

This block is the host-facing register front end of one UART channel. A narrow bus (3-bit address, 8-bit write and read data, separate read and write strobes) reaches more registers than it has addresses. The value currently held in the line control register, an enable bit in the enhanced feature register and a select bit in the modem control register together decide which physical register each address lands on. The block stores the baud divisor bytes, two pairs of flow-control characters, the enhanced feature, transmission control, trigger level, modem control and line control registers, and presents them as configuration outputs to the rest of the channel.

In the normal bank, address 0 is the data port. A read there produces a receive-pop strobe, and a write there produces a transmit-push strobe that carries the byte. Neither touches configuration storage. A read of address 7 can also return a FIFO-ready status word supplied by the data path. Software changes bank by rewriting the line control register, which is reachable in every bank, and restores the previous bank by writing back the value it saved.

Top module: `uart_regbank_dec`

## Requirements
- R1: After reset the line control register is 0x03, every other stored register is 0x00, and both strobes are low.
- R2: When line control equals 0x80 (divisor bank), address 0 reads and writes the divisor low byte (cfg_div[7:0]), address 1 the high byte (cfg_div[15:8]), and address 2 is unmapped.
- R3: When line control equals 0xBF (enhanced bank), address 2 is the enhanced feature register, 4 is Xon1, 5 is Xon2, 6 is Xoff1 and 7 is Xoff2.
- R4: Address 6 reaches the transmission control register and address 7 the trigger level register only when enhanced-feature bit 4 = 1, modem-control bit 6 = 1 and line control is not 0xBF. This also holds in the divisor bank. Otherwise address 6 is unmapped outside the enhanced bank.
- R5: Address 3 reads and writes the line control register in every bank.
- R6: Address 4 reaches the modem control register whenever line control is not 0xBF.
- R7: Each stored register reads back the last value accepted for it, and its configuration output equals that value.
- R8: Outside the enhanced bank and when the trigger level register is not selected, a read of address 7 returns fifo_rdy_in if modem-control bit 4 = 0, and returns 0x00 if that bit is 1. Writes there are ignored.
- R9: A write to the modem control register changes bit 6 only while enhanced-feature bit 4 = 1. Otherwise bit 6 keeps its old value and the other bits take the written value.
- R10: In the normal bank (line control neither 0x80 nor 0xBF), a read of address 0 returns 0x00 and raises rx_pop in the following cycle. A write there raises tx_push in the following cycle with tx_byte equal to the written byte. No stored register changes. Accesses to address 0 in other banks raise no strobe.
- R11: Unmapped addresses read 0x00, and writes to them change no stored register.
- R12: When read and write are both high in one cycle, the read data and both strobes are decoded from the state before the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, combinational from address and state |
| fifo_rdy_in | input | 8 | FIFO-ready status word from the data path |
| rx_pop | output | 1 | Receive-read strobe, one cycle per sampled read |
| tx_push | output | 1 | Transmit-write strobe, one cycle per sampled write |
| tx_byte | output | 8 | Byte that goes with tx_push |
| cfg_div | output | 16 | Divisor {high, low} |
| cfg_lcr | output | 8 | Line control register |
| cfg_mcr | output | 8 | Modem control register |
| cfg_efr | output | 8 | Enhanced feature register |
| cfg_xon1 | output | 8 | First Xon character |
| cfg_xon2 | output | 8 | Second Xon character |
| cfg_xoff1 | output | 8 | First Xoff character |
| cfg_xoff2 | output | 8 | Second Xoff character |
| cfg_tcr | output | 8 | Transmission control register |
| cfg_tlr | output | 8 | Trigger level register |

## Verification
The receive-pop and transmit-push strobes can fall in the same cycle when the host raises read and write together on address 0 of the normal bank. The bench does this and expects both strobes one cycle later, with tx_byte equal to the written byte. The same dual access on address 3 pairs a read with a bank change. There the bench expects the old line control value on the read data and the new value on cfg_lcr after the edge. A sweep over line control values, enable bits and addresses compares every read and every configuration output against a bench-side model.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;
  localparam int DW  = 8;
  localparam int AW  = 3;
  localparam int TGW = 4;

  localparam logic [DW-1:0] KEY_DIV = 8'h80;
  localparam logic [DW-1:0] KEY_ENH = 8'hBF;
  localparam logic [DW-1:0] LCR_RST = 8'h03;

  localparam int EFR_ENH_BIT = 4;
  localparam int MCR_ALT_BIT = 6;
  localparam int MCR_FRR_BIT = 4;

  typedef enum logic [TGW-1:0] {
    TG_NONE  = 4'd0,
    TG_DATA  = 4'd1,
    TG_DLL   = 4'd2,
    TG_DLH   = 4'd3,
    TG_LCR   = 4'd4,
    TG_MCR   = 4'd5,
    TG_EFR   = 4'd6,
    TG_XON1  = 4'd7,
    TG_XON2  = 4'd8,
    TG_XOFF1 = 4'd9,
    TG_XOFF2 = 4'd10,
    TG_TCR   = 4'd11,
    TG_TLR   = 4'd12,
    TG_FRR   = 4'd13
  } tgt_e;

  typedef enum logic [1:0] {BK_NORM, BK_DIV, BK_ENH} bank_e;

  // stored slots are the targets TG_DLL .. TG_TLR, in enum order
  localparam int SLOT_BASE = 2;
  localparam int NSLOT     = 11;
  localparam int S_DLL = 0, S_DLH = 1, S_LCR = 2, S_MCR = 3, S_EFR = 4;
  localparam int S_XON1 = 5, S_XON2 = 6, S_XOFF1 = 7, S_XOFF2 = 8;
  localparam int S_TCR = 9, S_TLR = 10;

  function automatic bank_e bank_of(input logic [DW-1:0] lcr);
    if (lcr == KEY_ENH)      return BK_ENH;
    else if (lcr == KEY_DIV) return BK_DIV;
    else                     return BK_NORM;
  endfunction

  function automatic tgt_e decode_tgt(input logic [AW-1:0] a,
                                      input logic [DW-1:0] lcr,
                                      input logic efr_en,
                                      input logic mcr_alt,
                                      input logic frr_off);
    bank_e b;
    logic  alt;
    tgt_e  t;
    b   = bank_of(lcr);
    alt = efr_en & mcr_alt & (b != BK_ENH);
    case (a)
      3'd0: t = (b == BK_DIV) ? TG_DLL : ((b == BK_NORM) ? TG_DATA : TG_NONE);
      3'd1: t = (b == BK_DIV) ? TG_DLH : TG_NONE;
      3'd2: t = (b == BK_ENH) ? TG_EFR : TG_NONE;
      3'd3: t = TG_LCR;
      3'd4: t = (b == BK_ENH) ? TG_XON1 : TG_MCR;
      3'd5: t = (b == BK_ENH) ? TG_XON2 : TG_NONE;
      3'd6: t = (b == BK_ENH) ? TG_XOFF1 : (alt ? TG_TCR : TG_NONE);
      default: t = (b == BK_ENH) ? TG_XOFF2 :
                   (alt ? TG_TLR : (frr_off ? TG_NONE : TG_FRR));
    endcase
    return t;
  endfunction

  function automatic logic [DW-1:0] slot_rst(input int slot);
    return (slot == S_LCR) ? LCR_RST : '0;
  endfunction

  function automatic logic [DW-1:0] slot_merge(input int slot,
                                               input logic [DW-1:0] old_v,
                                               input logic [DW-1:0] new_v,
                                               input logic unlock);
    logic [DW-1:0] r;
    r = new_v;
    if (slot == S_MCR && !unlock) r[MCR_ALT_BIT] = old_v[MCR_ALT_BIT];
    return r;
  endfunction
endpackage

// File: rtl/uart_rb_decode.sv
module uart_rb_decode
  import uart_rb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] lcr,
  input  logic [DW-1:0] efr,
  input  logic [DW-1:0] mcr,
  output tgt_e          tgt,
  output logic          is_norm
);
  bank_e bank;

  always_comb begin
    bank    = bank_of(lcr);
    is_norm = (bank == BK_NORM);
    tgt     = decode_tgt(addr, lcr, efr[EFR_ENH_BIT], mcr[MCR_ALT_BIT],
                         mcr[MCR_FRR_BIT]);
  end

  AST_LCR_EVERY_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 3'd3) |-> (tgt == TG_LCR)); // R5
  AST_ENH_HIDES_ALT: assert property (@(posedge clk) disable iff (!rst_n)
    (lcr == KEY_ENH) |-> (tgt != TG_TCR && tgt != TG_TLR)); // R4
  AST_ALT_NEEDS_KEYS: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt == TG_TCR || tgt == TG_TLR) |-> (efr[EFR_ENH_BIT] && mcr[MCR_ALT_BIT])); // R4
endmodule

// File: rtl/uart_rb_regfile.sv
module uart_rb_regfile
  import uart_rb_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  tgt_e                tgt,
  input  logic [DW-1:0]       wdata,
  output logic [NSLOT*DW-1:0] slots
);
  logic [DW-1:0] efr_q;
  logic [DW-1:0] mcr_q;
  logic          hit_vec [NSLOT];
  logic [NSLOT-1:0] hit_bits;

  assign efr_q = slots[S_EFR*DW +: DW];
  assign mcr_q = slots[S_MCR*DW +: DW];

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic [DW-1:0] q;
    assign hit_vec[i]  = we && (tgt == TGW'(SLOT_BASE + i));
    assign hit_bits[i] = hit_vec[i];
    always_ff @(posedge clk) begin
      if (!rst_n)          q <= slot_rst(i);
      else if (hit_vec[i]) q <= slot_merge(i, q, wdata, efr_q[EFR_ENH_BIT]);
    end
    assign slots[i*DW +: DW] = q;
  end

  AST_ONE_SLOT_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_bits)); // R11
  AST_MCR_ALT_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_bits[S_MCR] && !efr_q[EFR_ENH_BIT]) |=>
      (mcr_q[MCR_ALT_BIT] == $past(mcr_q[MCR_ALT_BIT]))); // R9
  AST_UNMAPPED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (tgt == TG_NONE || tgt == TG_FRR)) |=> $stable(slots)); // R11
endmodule

// File: rtl/uart_rb_rdmux.sv
module uart_rb_rdmux
  import uart_rb_pkg::*;
(
  input  tgt_e                tgt,
  input  logic [NSLOT*DW-1:0] slots,
  input  logic [DW-1:0]       frr,
  output logic [DW-1:0]       rdata
);
  always_comb begin
    case (tgt)
      TG_NONE, TG_DATA: rdata = '0;
      TG_FRR:           rdata = frr;
      default:          rdata = slots[(int'(tgt) - SLOT_BASE)*DW +: DW];
    endcase
  end

  always_comb begin
    if (tgt == TG_NONE) begin
      AST_UNMAPPED_READS_ZERO: assert (rdata == '0); // R11
    end
  end
endmodule

// File: rtl/uart_rb_strobe.sv
module uart_rb_strobe
  import uart_rb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd,
  input  logic          wr,
  input  tgt_e          tgt,
  input  logic [DW-1:0] wdata,
  output logic          rx_pop,
  output logic          tx_push,
  output logic [DW-1:0] tx_byte
);
  logic data_hit;
  assign data_hit = (tgt == TG_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_pop  <= 1'b0;
      tx_push <= 1'b0;
      tx_byte <= '0;
    end else begin
      rx_pop  <= rd && data_hit;
      tx_push <= wr && data_hit;
      if (wr && data_hit) tx_byte <= wdata;
    end
  end

  AST_POP_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> $past(rd)); // R10
  AST_PUSH_CARRIES_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |-> ($past(wr) && tx_byte == $past(wdata))); // R10
endmodule

// File: rtl/uart_regbank_dec.sv
module uart_regbank_dec
  import uart_rb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_wr,
  input  logic          bus_rd,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] fifo_rdy_in,
  output logic          rx_pop,
  output logic          tx_push,
  output logic [DW-1:0] tx_byte,
  output logic [2*DW-1:0] cfg_div,
  output logic [DW-1:0] cfg_lcr,
  output logic [DW-1:0] cfg_mcr,
  output logic [DW-1:0] cfg_efr,
  output logic [DW-1:0] cfg_xon1,
  output logic [DW-1:0] cfg_xon2,
  output logic [DW-1:0] cfg_xoff1,
  output logic [DW-1:0] cfg_xoff2,
  output logic [DW-1:0] cfg_tcr,
  output logic [DW-1:0] cfg_tlr
);
  tgt_e                tgt;
  logic                is_norm;
  logic [NSLOT*DW-1:0] slots;

  assign cfg_div   = {slots[S_DLH*DW +: DW], slots[S_DLL*DW +: DW]};
  assign cfg_lcr   = slots[S_LCR*DW +: DW];
  assign cfg_mcr   = slots[S_MCR*DW +: DW];
  assign cfg_efr   = slots[S_EFR*DW +: DW];
  assign cfg_xon1  = slots[S_XON1*DW +: DW];
  assign cfg_xon2  = slots[S_XON2*DW +: DW];
  assign cfg_xoff1 = slots[S_XOFF1*DW +: DW];
  assign cfg_xoff2 = slots[S_XOFF2*DW +: DW];
  assign cfg_tcr   = slots[S_TCR*DW +: DW];
  assign cfg_tlr   = slots[S_TLR*DW +: DW];

  uart_rb_decode u_dec (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr),
    .lcr(cfg_lcr), .efr(cfg_efr), .mcr(cfg_mcr),
    .tgt(tgt), .is_norm(is_norm)
  );

  uart_rb_regfile u_rf (
    .clk(clk), .rst_n(rst_n), .we(bus_wr), .tgt(tgt),
    .wdata(bus_wdata), .slots(slots)
  );

  uart_rb_rdmux u_rd (
    .tgt(tgt), .slots(slots), .frr(fifo_rdy_in), .rdata(bus_rdata)
  );

  uart_rb_strobe u_stb (
    .clk(clk), .rst_n(rst_n), .rd(bus_rd), .wr(bus_wr), .tgt(tgt),
    .wdata(bus_wdata), .rx_pop(rx_pop), .tx_push(tx_push), .tx_byte(tx_byte)
  );

  AST_DATA_PORT_KEEPS_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd0 && is_norm) |=> $stable(cfg_div)); // R10
  AST_STROBE_ONLY_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rd || bus_wr) && bus_addr == 3'd0 && !is_norm) |=> (!rx_pop && !tx_push)); // R10
endmodule

// File: tb/test_uart_regbank_dec.sv
module test_uart_regbank_dec;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata, fifo_rdy_in, tx_byte;
  logic       bus_wr, bus_rd, rx_pop, tx_push;
  logic [15:0] cfg_div;
  logic [7:0] cfg_lcr, cfg_mcr, cfg_efr, cfg_xon1, cfg_xon2, cfg_xoff1, cfg_xoff2, cfg_tcr, cfg_tlr;

  int n_chk = 0;
  int n_bad = 0;

  // bench model
  logic [7:0] m_dll, m_dlh, m_lcr, m_mcr, m_efr, m_xon1, m_xon2, m_xoff1, m_xoff2, m_tcr, m_tlr;

  always #(CLK_P/2) clk = ~clk;

  uart_regbank_dec i_uart_regbank_dec (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .fifo_rdy_in(fifo_rdy_in),
    .rx_pop(rx_pop), .tx_push(tx_push), .tx_byte(tx_byte), .cfg_div(cfg_div),
    .cfg_lcr(cfg_lcr), .cfg_mcr(cfg_mcr), .cfg_efr(cfg_efr), .cfg_xon1(cfg_xon1),
    .cfg_xon2(cfg_xon2), .cfg_xoff1(cfg_xoff1), .cfg_xoff2(cfg_xoff2),
    .cfg_tcr(cfg_tcr), .cfg_tlr(cfg_tlr)
  );

  task automatic chk(input logic ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [2:0] a);
    logic alt;
    alt = m_efr[4] && m_mcr[6];
    if (m_lcr == 8'hBF) begin
      if (a == 3'd2) return m_efr;
      if (a == 3'd3) return m_lcr;
      if (a == 3'd4) return m_xon1;
      if (a == 3'd5) return m_xon2;
      if (a == 3'd6) return m_xoff1;
      if (a == 3'd7) return m_xoff2;
      return 8'h00;
    end
    if (a == 3'd0) return (m_lcr == 8'h80) ? m_dll : 8'h00;
    if (a == 3'd1) return (m_lcr == 8'h80) ? m_dlh : 8'h00;
    if (a == 3'd3) return m_lcr;
    if (a == 3'd4) return m_mcr;
    if (a == 3'd6) return alt ? m_tcr : 8'h00;
    if (a == 3'd7) return alt ? m_tlr : (m_mcr[4] ? 8'h00 : fifo_rdy_in);
    return 8'h00;
  endfunction

  task automatic model_write(input logic [2:0] a, input logic [7:0] d);
    logic alt;
    alt = m_efr[4] && m_mcr[6];
    if (a == 3'd3) m_lcr = d;
    else if (m_lcr == 8'hBF) begin
      case (a)
        3'd2: m_efr = d;
        3'd4: m_xon1 = d;
        3'd5: m_xon2 = d;
        3'd6: m_xoff1 = d;
        3'd7: m_xoff2 = d;
        default: ;
      endcase
    end else begin
      if (a == 3'd0 && m_lcr == 8'h80) m_dll = d;
      if (a == 3'd1 && m_lcr == 8'h80) m_dlh = d;
      if (a == 3'd4) m_mcr = {d[7], (m_efr[4] ? d[6] : m_mcr[6]), d[5:0]};
      if (a == 3'd6 && alt) m_tcr = d;
      if (a == 3'd7 && alt) m_tlr = d;
    end
  endtask

  task automatic check_cfg(input string tag);
    chk({cfg_div, cfg_lcr, cfg_mcr, cfg_efr, cfg_xon1, cfg_xon2, cfg_xoff1, cfg_xoff2, cfg_tcr, cfg_tlr} ==
        {m_dlh, m_dll, m_lcr, m_mcr, m_efr, m_xon1, m_xon2, m_xoff1, m_xoff2, m_tcr, m_tlr}, tag,
        {cfg_div, cfg_lcr, cfg_mcr, cfg_efr, cfg_xon1, cfg_xon2, cfg_xoff1, cfg_xoff2, cfg_tcr, cfg_tlr},
        {m_dlh, m_dll, m_lcr, m_mcr, m_efr, m_xon1, m_xon2, m_xoff1, m_xoff2, m_tcr, m_tlr});
  endtask

  // one bus cycle: drive at negedge, read data checked mid-cycle, strobes and config after the edge
  task automatic access(input logic [2:0] a, input logic [7:0] d, input logic r, input logic w, input string tag);
    logic dport, e_pop, e_push;
    logic [7:0] e_rd;
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_rd = r; bus_wr = w;
    dport  = (a == 3'd0) && (m_lcr != 8'h80) && (m_lcr != 8'hBF);
    e_pop  = r && dport;
    e_push = w && dport;
    e_rd   = exp_read(a);
    #1;
    if (r) chk(bus_rdata == e_rd, {tag, " rdata"}, bus_rdata, e_rd);
    if (w) model_write(a, d);
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    chk(rx_pop == e_pop && tx_push == e_push, {tag, " R10 strobes"}, {rx_pop, tx_push}, {e_pop, e_push});
    if (e_push) chk(tx_byte == d, {tag, " R10 tx_byte"}, tx_byte, d);
    if (w) check_cfg({tag, " R7 R11 cfg"});
  endtask

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] lcr_list [4];
    lcr_list[0] = 8'h03; lcr_list[1] = 8'h80; lcr_list[2] = 8'hBF; lcr_list[3] = 8'h1B;
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    fifo_rdy_in = 8'hA5;
    {m_dll, m_dlh, m_mcr, m_efr, m_xon1, m_xon2, m_xoff1, m_xoff2, m_tcr, m_tlr} = '0;
    m_lcr = 8'h03;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_cfg("R1 reset cfg");
    chk(!rx_pop && !tx_push, "R1 strobes idle", {rx_pop, tx_push}, 2'b00);
    access(3'd3, 8'h00, 1'b1, 1'b0, "R1 R5 lcr reset");
    access(3'd7, 8'h00, 1'b1, 1'b0, "R8 frr after reset");
    access(3'd0, 8'h00, 1'b1, 1'b0, "R10 pop");

    // R9 MCR bit 6 lock
    access(3'd4, 8'h40, 1'b0, 1'b1, "R9 locked");
    chk(cfg_mcr[6] == 1'b0, "R9 bit6 stays", cfg_mcr, 8'h00);
    access(3'd3, 8'hBF, 1'b0, 1'b1, "R3 enter enh");
    access(3'd2, 8'h10, 1'b0, 1'b1, "R3 efr write");
    access(3'd3, 8'h00, 1'b0, 1'b1, "R5 leave enh");
    access(3'd4, 8'h40, 1'b0, 1'b1, "R9 unlocked");
    chk(cfg_mcr[6] == 1'b1, "R9 bit6 set", cfg_mcr, 8'h40);
    access(3'd6, 8'h3C, 1'b0, 1'b1, "R4 tcr write");
    chk(cfg_tcr == 8'h3C, "R4 tcr", cfg_tcr, 8'h3C);
    access(3'd3, 8'h80, 1'b0, 1'b1, "R2 enter div");
    access(3'd7, 8'h77, 1'b1, 1'b1, "R4 tlr in div bank");
    chk(cfg_tlr == 8'h77, "R4 tlr", cfg_tlr, 8'h77);
    access(3'd0, 8'h12, 1'b0, 1'b1, "R2 dll");
    access(3'd1, 8'h34, 1'b0, 1'b1, "R2 dlh");
    chk(cfg_div == 16'h3412, "R2 divisor", cfg_div, 16'h3412);
    access(3'd2, 8'hEE, 1'b1, 1'b1, "R2 R11 addr2 unmapped");

    // R12 simultaneous read and write
    access(3'd3, 8'h07, 1'b1, 1'b1, "R12 lcr rd+wr");
    chk(cfg_lcr == 8'h07, "R12 lcr new", cfg_lcr, 8'h07);
    access(3'd0, 8'hC3, 1'b1, 1'b1, "R12 data rd+wr");
    chk(cfg_div == 16'h3412, "R10 div untouched", cfg_div, 16'h3412);
    access(3'd3, 8'h80, 1'b1, 1'b1, "R12 into div");
    access(3'd0, 8'h99, 1'b1, 1'b1, "R12 div rd+wr");

    // sweep: line control value x enable bits x address
    for (int li = 0; li < 4; li++) begin
      for (int k = 0; k < 8; k++) begin
        fifo_rdy_in = 8'h5A ^ 8'(li * 8 + k);
        access(3'd3, 8'hBF, 1'b0, 1'b1, "R3 setup");
        access(3'd2, {3'b000, k[0], 4'h0}, 1'b0, 1'b1, "R3 setup efr");
        access(3'd3, 8'h00, 1'b0, 1'b1, "R5 setup");
        access(3'd4, {1'b0, k[1], 1'b0, k[2], 4'h0}, 1'b0, 1'b1, "R6 R9 setup mcr");
        access(3'd3, lcr_list[li], 1'b0, 1'b1, "R5 setup bank");
        for (int a = 0; a < 8; a++) begin
          logic [7:0] d;
          if (a == 3) continue;
          d = 8'(a * 37 + li * 11 + k * 5 + 1);
          if (m_lcr == 8'hBF && a == 2) d = (d & 8'hEF) | (m_efr & 8'h10);
          if (m_lcr != 8'hBF && a == 4) d = (d & 8'hAF) | (m_mcr & 8'h50);
          access(3'(a), d, 1'b0, 1'b1, "R2 R3 R4 R6 R11 sweep wr");
        end
        for (int a = 0; a < 8; a++)
          access(3'(a), 8'h00, 1'b1, 1'b0, "R2 R3 R4 R5 R7 R8 sweep rd");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule